// File: doc/BRIEF.md
# Variable-Occupancy Micro-Op Queue

This block is an in-order circular buffer that sits between an instruction front end and an out-of-order backend. Each cycle up to `LANES` instruction tokens arrive in parallel, and each carries an identifier and a micro-op count. A token takes as many queue entries as its micro-op count. The count is normalized before use: zero becomes one, and anything above the queue depth becomes the depth. Because of the clamp, a heavily microcoded instruction still fits into an empty queue. Tokens leave in arrival order on a single valid/ready output, at most one per cycle, and the output carries only the identifier.

Two parameters shape the timing. `MAX_IPC` caps how many tokens may be written in one cycle, and zero means no cap. `ZERO_LAT` picks one of two modes. When it is set, a token arriving on lane 0 while the queue is empty is offered on the output in the same cycle. When it is clear, every token waits at least one cycle in storage. Each token is written at the slot the write pointer names. The write pointer then advances by the token's normalized count, wrapping at `DEPTH`. A per-slot count field lets the read pointer skip the same distance when the token leaves. The `busy` output shows that some entries are in use.

Top module: `uop_queue`

## Requirements
- R1: A token whose micro-op count exceeds `DEPTH` consumes exactly `DEPTH` entries. It is accepted into an empty queue, and nothing else is accepted until it leaves.
- R2: A token with a micro-op count of 0 consumes exactly one entry.
- R3: `in_ready[i]` is high only if every lane below `i` is both valid and accepted, and the normalized counts of lanes 0 to `i` together fit in the free entries held at the start of the cycle. A lane is accepted when both `in_valid[i]` and `in_ready[i]` are high.
- R4: When `MAX_IPC` is nonzero, `in_ready[i]` is low for every lane `i >= MAX_IPC`, so at most `MAX_IPC` tokens are written per cycle. The limit applies afresh in every cycle.
- R5: With `ZERO_LAT=1` and an empty queue, an accepted lane-0 token drives `out_valid` high with its identifier in the same cycle.
- R6: With `ZERO_LAT=0`, `out_valid` is high only when the queue held a token at the start of the cycle.
- R7: `busy` is high exactly when the free-entry count is below `DEPTH`.
- R8: Tokens leave in acceptance order, at most one per cycle, and the pointers wrap modulo `DEPTH`. A departure returns the token's normalized count to the free pool. While `out_ready` is low, a valid output holds its identifier.
- R9: A synchronous reset with `rst_n` low empties the queue: `out_valid` low, `busy` low, all `DEPTH` entries free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | LANES | Per-lane token present |
| in_id | input | LANES x ID_W | Per-lane token identifier |
| in_uops | input | LANES x CNT_W | Per-lane micro-op count |
| in_ready | output | LANES | Per-lane acceptance |
| out_valid | output | 1 | Oldest token offered downstream |
| out_ready | input | 1 | Downstream takes the offered token |
| out_id | output | ID_W | Identifier of the offered token |
| busy | output | 1 | Some entries are occupied |

## Verification
On every cycle, the assertions check four properties. The free count never exceeds the depth, and an empty queue has every entry free. The accepted lanes never exceed the cap or the free space. A stalled output keeps its identifier, and delay mode never offers a token that is not yet stored. Only the bench's scenarios can show that identifiers come out in order and that clamped, zero-count and multi-lane tokens give back exactly the entries they took. They also confirm that the same-cycle bypass appears only in zero-latency mode. The bench runs both a zero-latency uncapped instance and a delayed, one-per-cycle instance against one reference model.

// File: rtl/uq_pkg.sv
`timescale 1ns/1ps
// Shared types for the micro-op queue.
// Assumes nothing beyond IEEE 1800-2017 packages.
package uq_pkg;
    // Which source feeds the output port in a given cycle.
    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_HEAD   = 2'd1,
        SRC_BYPASS = 2'd2
    } uq_src_e;
endpackage

// File: rtl/uq_admit.sv
`timescale 1ns/1ps
// Admission logic: normalizes each lane's micro-op count and decides which
// lanes are accepted this cycle. Lanes are taken in order, so the accepted
// lanes always form a prefix. Also reports each lane's entry offset from the
// write pointer.
// Assumes free_cnt is the registered free count, which is <= DEPTH.
module uq_admit #(
    parameter int DEPTH   = 8,
    parameter int LANES   = 2,
    parameter int CNT_W   = 4,
    parameter int MAX_IPC = 0,
    parameter int NW      = 4,
    parameter int SW      = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LANES-1:0]           in_valid,
    input  logic [LANES-1:0][CNT_W-1:0] in_uops,
    input  logic [NW-1:0]              free_cnt,
    output logic [LANES-1:0]           in_ready,
    output logic [LANES-1:0]           acc,
    output logic [LANES-1:0][NW-1:0]   norm,
    output logic [LANES-1:0][SW-1:0]   offs,
    output logic [SW-1:0]              acc_sum,
    output logic [NW-1:0]              acc_num
);
    // Per lane: clamp the count to [1, DEPTH].
    for (genvar g = 0; g < LANES; g++) begin : g_norm
        always_comb begin
            if (in_uops[g] == '0)
                norm[g] = NW'(1);
            else if (int'(in_uops[g]) >= DEPTH)
                norm[g] = NW'(DEPTH);
            else
                norm[g] = NW'(in_uops[g]);
        end
    end

    // In-order prefix acceptance under the cap and the free space.
    always_comb begin
        logic          chain;
        logic [SW-1:0] run;
        logic [NW-1:0] num;
        chain = 1'b1;
        run   = '0;
        num   = '0;
        for (int i = 0; i < LANES; i++) begin
            in_ready[i] = chain && (MAX_IPC == 0 || i < MAX_IPC)
                          && ((run + SW'(norm[i])) <= SW'(free_cnt));
            offs[i] = run;
            acc[i]  = chain && in_valid[i] && in_ready[i];
            if (acc[i]) begin
                run = run + SW'(norm[i]);
                num = num + NW'(1);
            end else begin
                chain = 1'b0;
            end
        end
        acc_sum = run;
        acc_num = num;
    end

    // R4: never more lanes accepted than the cap.
    a_r4_ipc_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (MAX_IPC != 0) |-> ($countones(in_valid & in_ready) <= MAX_IPC));

    // R3: what is accepted always fits in the free entries.
    a_r3_fits_free: assert property (@(posedge clk) disable iff (!rst_n)
        acc_sum <= SW'(free_cnt));
endmodule

// File: rtl/uq_slots.sv
`timescale 1ns/1ps
// Slot storage: one identifier and one normalized count per slot. Only the
// first slot of a token is written. The head slot is read asynchronously.
// Assumes the write addresses of one cycle are distinct.
module uq_slots #(
    parameter int DEPTH = 8,
    parameter int LANES = 2,
    parameter int ID_W  = 6,
    parameter int NW    = 4,
    parameter int PW    = 3
) (
    input  logic                       clk,
    input  logic [LANES-1:0]           wr_en,
    input  logic [LANES-1:0][PW-1:0]   wr_addr,
    input  logic [LANES-1:0][ID_W-1:0] wr_id,
    input  logic [LANES-1:0][NW-1:0]   wr_n,
    input  logic [PW-1:0]              rd_addr,
    output logic [ID_W-1:0]            rd_id,
    output logic [NW-1:0]              rd_n
);
    logic [ID_W-1:0] id_mem [DEPTH];
    logic [NW-1:0]   n_mem  [DEPTH];

    // Write each accepted lane into its first slot.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wr_en[i]) begin
                id_mem[wr_addr[i]] <= wr_id[i];
                n_mem[wr_addr[i]]  <= wr_n[i];
            end
        end
    end

    // Present the head slot.
    assign rd_id = id_mem[rd_addr];
    assign rd_n  = n_mem[rd_addr];
endmodule

// File: rtl/uq_egress.sv
`timescale 1ns/1ps
// Output selection: the stored head has priority. In zero-latency mode, an
// empty queue forwards the accepted lane-0 token directly. Reports the pop
// and the number of entries that pop returns.
// Assumes has_head is registered state, so there is no loop through out_ready.
module uq_egress #(
    parameter int ID_W     = 6,
    parameter int NW       = 4,
    parameter int ZERO_LAT = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            has_head,
    input  logic [ID_W-1:0] head_id,
    input  logic [NW-1:0]   head_n,
    input  logic            byp_ok,
    input  logic [ID_W-1:0] byp_id,
    input  logic [NW-1:0]   byp_n,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [ID_W-1:0] out_id,
    output logic            pop,
    output logic [NW-1:0]   pop_n
);
    import uq_pkg::*;

    logic    byp_path;
    uq_src_e src;

    // The mode parameter decides whether the bypass path exists.
    if (ZERO_LAT != 0) begin : g_zl
        assign byp_path = byp_ok;
    end else begin : g_dly
        assign byp_path = 1'b0;
    end

    // Pick the source for this cycle.
    always_comb begin
        if (has_head)      src = SRC_HEAD;
        else if (byp_path) src = SRC_BYPASS;
        else               src = SRC_NONE;
    end

    // Drive the output and the returned entry count from the chosen source.
    always_comb begin
        case (src)
            SRC_HEAD:   begin out_valid = 1'b1; out_id = head_id; pop_n = head_n; end
            SRC_BYPASS: begin out_valid = 1'b1; out_id = byp_id;  pop_n = byp_n;  end
            default:    begin out_valid = 1'b0; out_id = '0;      pop_n = '0;     end
        endcase
        pop = out_valid && out_ready;
    end

    // R8: a stalled output keeps its token.
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_id)));

    // R6: delay mode offers only tokens already in storage.
    a_r6_delay_stored: assert property (@(posedge clk) disable iff (!rst_n)
        (ZERO_LAT == 0 && out_valid) |-> has_head);
endmodule

// File: rtl/uop_queue.sv
`timescale 1ns/1ps
// Variable-occupancy micro-op queue (top). Holds the write and read pointers,
// the free-entry count and the token count, and joins admission, storage and
// egress. Each token takes its normalized micro-op count in entries.
// Assumes DEPTH >= 2 and a synchronous active-low reset.
module uop_queue #(
    parameter int DEPTH    = 8,
    parameter int LANES    = 2,
    parameter int ID_W     = 6,
    parameter int CNT_W    = 4,
    parameter int MAX_IPC  = 0,
    parameter int ZERO_LAT = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0]            in_valid,
    input  logic [LANES-1:0][ID_W-1:0]  in_id,
    input  logic [LANES-1:0][CNT_W-1:0] in_uops,
    output logic [LANES-1:0]            in_ready,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [ID_W-1:0]             out_id,
    output logic                        busy
);
    localparam int PW = $clog2(DEPTH);
    localparam int NW = $clog2(DEPTH + 1);
    localparam int SW = $clog2((LANES + 1) * DEPTH + 1);

    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [NW-1:0] free_cnt, tok_cnt;

    logic [LANES-1:0]          acc;
    logic [LANES-1:0][NW-1:0]  norm;
    logic [LANES-1:0][SW-1:0]  offs;
    logic [LANES-1:0][PW-1:0]  slot;
    logic [SW-1:0]             acc_sum;
    logic [NW-1:0]             acc_num;
    logic [ID_W-1:0]           head_id;
    logic [NW-1:0]             head_n, pop_n;
    logic                      pop;

    // Modulo-DEPTH add for a pointer plus an offset no larger than DEPTH.
    function automatic logic [PW-1:0] wrap(input logic [SW-1:0] v);
        if (v >= SW'(DEPTH)) return PW'(v - SW'(DEPTH));
        else                 return PW'(v);
    endfunction

    uq_admit #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W), .MAX_IPC(MAX_IPC),
               .NW(NW), .SW(SW)) u_admit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_uops(in_uops),
        .free_cnt(free_cnt), .in_ready(in_ready), .acc(acc), .norm(norm),
        .offs(offs), .acc_sum(acc_sum), .acc_num(acc_num)
    );

    // First slot of each lane: write pointer plus the lane's offset.
    for (genvar g = 0; g < LANES; g++) begin : g_slot
        assign slot[g] = wrap(SW'(wr_ptr) + offs[g]);
    end

    uq_slots #(.DEPTH(DEPTH), .LANES(LANES), .ID_W(ID_W), .NW(NW), .PW(PW)) u_slots (
        .clk(clk), .wr_en(acc), .wr_addr(slot), .wr_id(in_id), .wr_n(norm),
        .rd_addr(rd_ptr), .rd_id(head_id), .rd_n(head_n)
    );

    uq_egress #(.ID_W(ID_W), .NW(NW), .ZERO_LAT(ZERO_LAT)) u_egress (
        .clk(clk), .rst_n(rst_n), .has_head(tok_cnt != '0), .head_id(head_id),
        .head_n(head_n), .byp_ok(acc[0]), .byp_id(in_id[0]), .byp_n(norm[0]),
        .out_ready(out_ready), .out_valid(out_valid), .out_id(out_id),
        .pop(pop), .pop_n(pop_n)
    );

    // Advance the pointers and the counts, or empty the queue on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            free_cnt <= NW'(DEPTH);
            tok_cnt  <= '0;
        end else begin
            wr_ptr   <= wrap(SW'(wr_ptr) + acc_sum);
            rd_ptr   <= wrap(SW'(rd_ptr) + (pop ? SW'(pop_n) : '0));
            free_cnt <= NW'(SW'(free_cnt) - acc_sum + (pop ? SW'(pop_n) : '0));
            tok_cnt  <= tok_cnt + acc_num - (pop ? NW'(1) : '0);
        end
    end

    // Report pending work.
    assign busy = (free_cnt != NW'(DEPTH));

    // R3: the free count never exceeds the depth.
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= NW'(DEPTH));

    // R7: with no token held, every entry is free.
    a_r7_empty_all_free: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_cnt == '0) |-> (free_cnt == NW'(DEPTH)));

    // R9: the first cycle after reset starts empty.
    a_r9_reset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (free_cnt == NW'(DEPTH) && tok_cnt == '0));
endmodule

// File: tb/uop_queue_bench.sv
`timescale 1ns/1ps
// Bench: two instances take the same stimulus. Instance A is zero-latency and
// uncapped. Instance B is delayed and capped at one token per cycle. Both are
// checked against a reference model kept in the bench.
module uop_queue_bench;
    localparam int DEPTH = 8;
    localparam int LANES = 2;
    localparam int ID_W  = 6;
    localparam int CNT_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0]            in_valid = '0;
    logic [LANES-1:0][ID_W-1:0]  in_id = '0;
    logic [LANES-1:0][CNT_W-1:0] in_uops = '0;
    logic                        out_ready = 1'b0;

    logic [LANES-1:0] rdy_a, rdy_b;
    logic             ov_a, ov_b, busy_a, busy_b;
    logic [ID_W-1:0]  oid_a, oid_b;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // Reference model state, one set per instance.
    int free_m [2];
    int cnt_m  [2];
    int hd_m   [2];
    int qid    [2][16];
    int qn     [2][16];

    always #10 clk = ~clk;

    uop_queue #(.DEPTH(DEPTH), .LANES(LANES), .ID_W(ID_W), .CNT_W(CNT_W),
                .MAX_IPC(0), .ZERO_LAT(1)) u_uop_queue (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
        .in_uops(in_uops), .in_ready(rdy_a), .out_valid(ov_a),
        .out_ready(out_ready), .out_id(oid_a), .busy(busy_a)
    );

    uop_queue #(.DEPTH(DEPTH), .LANES(LANES), .ID_W(ID_W), .CNT_W(CNT_W),
                .MAX_IPC(1), .ZERO_LAT(0)) u_uop_queue_dly (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
        .in_uops(in_uops), .in_ready(rdy_b), .out_valid(ov_b),
        .out_ready(out_ready), .out_id(oid_b), .busy(busy_b)
    );

    function automatic int nrm(input int u);
        if (u == 0) return 1;
        if (u > DEPTH) return DEPTH;
        return u;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // One cycle: drive the inputs, check both instances, advance the model.
    task automatic cyc(input logic [1:0] v, input int id0, input int id1,
                       input int u0, input int u1, input logic ordy,
                       input string tag);
        int n [2];
        @(negedge clk);
        in_valid   = v;
        in_id[0]   = ID_W'(id0);
        in_id[1]   = ID_W'(id1);
        in_uops[0] = CNT_W'(u0);
        in_uops[1] = CNT_W'(u1);
        out_ready  = ordy;
        n[0] = nrm(u0);
        n[1] = nrm(u1);
        #2;
        for (int k = 0; k < 2; k++) begin
            int run = 0;
            bit chain = 1'b1;
            bit erdy [2];
            bit acc [2];
            bit ev;
            int eid;
            for (int i = 0; i < 2; i++) begin
                erdy[i] = chain && (k == 0 || i < 1) && (run + n[i] <= free_m[k]);
                acc[i]  = chain && v[i] && erdy[i];
                if (acc[i]) run += n[i];
                else chain = 1'b0;
                chk(((k == 0) ? rdy_a[i] : rdy_b[i]) == erdy[i],
                    (k == 1 && i == 1) ? "R4" : tag, "in_ready",
                    int'((k == 0) ? rdy_a[i] : rdy_b[i]), int'(erdy[i]));
            end
            ev  = (cnt_m[k] > 0) || (k == 0 && acc[0]);
            eid = (cnt_m[k] > 0) ? qid[k][hd_m[k]] : id0;
            chk(((k == 0) ? ov_a : ov_b) == ev, (k == 0) ? "R5" : "R6",
                "out_valid", int'((k == 0) ? ov_a : ov_b), int'(ev));
            if (ev)
                chk(int'((k == 0) ? oid_a : oid_b) == eid, "R8", "out_id",
                    int'((k == 0) ? oid_a : oid_b), eid);
            chk(((k == 0) ? busy_a : busy_b) == (free_m[k] < DEPTH), "R7", "busy",
                int'((k == 0) ? busy_a : busy_b), int'(free_m[k] < DEPTH));
            // Model update: push the accepted lanes, then pop the front.
            for (int i = 0; i < 2; i++) begin
                if (acc[i]) begin
                    qid[k][(hd_m[k] + cnt_m[k]) % 16] = (i == 0) ? id0 : id1;
                    qn[k][(hd_m[k] + cnt_m[k]) % 16]  = n[i];
                    cnt_m[k]++;
                end
            end
            free_m[k] -= run;
            if (ev && ordy) begin
                free_m[k] += qn[k][hd_m[k]];
                hd_m[k] = (hd_m[k] + 1) % 16;
                cnt_m[k]--;
            end
        end
    endtask

    task automatic drain();
        for (int i = 0; i < 10; i++) cyc(2'b00, 0, 0, 0, 0, 1'b1, "R8");
    endtask

    initial begin
        void'($urandom(32'd20240607));
        for (int k = 0; k < 2; k++) begin
            free_m[k] = DEPTH;
            cnt_m[k]  = 0;
            hd_m[k]   = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: state right after reset
        cyc(2'b00, 0, 0, 1, 1, 1'b0, "R9");

        // R1: an oversized count fills the queue and blocks the next token
        cyc(2'b01, 5, 0, 15, 0, 1'b0, "R1");
        cyc(2'b01, 6, 0, 1, 0, 1'b0, "R1");
        drain();

        // R2: a zero-count token takes one entry, so 7 more still fit
        cyc(2'b11, 9, 10, 0, 7, 1'b0, "R2");
        cyc(2'b01, 11, 0, 1, 0, 1'b0, "R2");
        drain();

        // R5: same-cycle bypass in zero-latency mode only
        cyc(2'b01, 20, 0, 2, 0, 1'b1, "R5");
        drain();

        // R3: lane 1 is refused when lane 0 is absent
        cyc(2'b10, 0, 21, 1, 1, 1'b0, "R3");
        drain();

        // R8: random traffic exercises ordering and wrap-around
        for (int t = 0; t < 3000; t++) begin
            logic [1:0] v = 2'($urandom);
            int u0 = ($urandom % 5 == 0) ? int'($urandom % 16) : int'($urandom % 4);
            int u1 = ($urandom % 5 == 0) ? int'($urandom % 16) : int'($urandom % 4);
            cyc(v, int'($urandom % 64), int'($urandom % 64), u0, u1,
                ($urandom % 10) < 7, "R3");
        end
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R8 got 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule